// File: doc/BRIEF.md
# Gapped Serial Port with Per-Bit Enables

This block joins a byte-wide parallel world to a bit-serial line in both directions. Every bit slot is qualified: each bit period is marked by a clock-enable strobe, and an enable pin decides whether that slot carries data. A missing strobe models a gapped clock edge, and it behaves the same as a blocked slot.

On the transmit side, bytes arrive through a valid/ready handshake and leave MSB first. The transmit enable is sampled one strobe before the slot it governs, so its level at strobe n decides whether the next bit goes out at strobe n+1. In a blocked slot the output keeps its last value and no data is lost. On the receive side, the enable has no lead: a serial bit enters the deserializer only when its own strobe sees the receive enable active. After eight accepted bits, a byte is presented with a one-cycle valid pulse.

Each enable has its own polarity bit. Both polarity bits are held in registers that load together on a configuration strobe. A single clock runs the whole block, with a synchronous reset.

Top module: `gapped_serial_port`

## Requirements
- R1: After synchronous reset, `tx_ser` is 0, `tx_ready` is 1 and `rx_valid` is 0. Both polarity registers are 0, meaning active-low.
- R2: A byte is taken on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` then stays low until that byte's first bit has been sent. Bytes leave MSB first.
- R3: The transmit enable level at one `tx_tick` decides whether a bit is sent at the next `tx_tick`. A bit that is sent appears on `tx_ser` in the cycle after that strobe's clock edge.
- R4: In a blocked transmit slot, `tx_ser` holds the last bit it drove. The pending bit is kept and goes out at the next slot that is allowed.
- R5: With transmit polarity 0, the enable is active when low. With polarity 1, it is active when high.
- R6: A cycle without `tx_tick` is a gapped edge. It neither sends a bit nor samples the transmit enable.
- R7: A bit is accepted when `rx_tick` is high and the receive enable is active in the same cycle. Accepted bits fill a byte MSB first. The eighth accepted bit makes `rx_valid` high for exactly one cycle, with the byte on `rx_data`. `rx_data` holds its value between completed bytes.
- R8: A bit with `rx_tick` low, or with the receive enable inactive, is dropped and does not count toward the byte.
- R9: Receive polarity works like transmit polarity (0 means active-low, 1 means active-high) and is set independently of it.
- R10: Both polarity registers load from `cfg_tx_pol`/`cfg_rx_pol` on a cycle with `cfg_load` high. A strobe in that same cycle still uses the old polarity.
- R11: An allowed transmit slot with no data queued sends nothing. `tx_ser` holds its value, and the next byte starts from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Loads both polarity registers |
| cfg_tx_pol | input | 1 | Transmit enable polarity to load (1 = active-high) |
| cfg_rx_pol | input | 1 | Receive enable polarity to load (1 = active-high) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte |
| tx_tick | input | 1 | Transmit bit-period strobe (low = gapped edge) |
| tx_en | input | 1 | Transmit enable, one slot ahead |
| tx_ser | output | 1 | Serial transmit data |
| rx_tick | input | 1 | Receive bit-period strobe |
| rx_en | input | 1 | Receive enable, same slot |
| rx_ser | input | 1 | Serial receive data |
| rx_data | output | 8 | Completed received byte |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_data` |

## Verification
Several events can fall in one cycle. A polarity reload can land on the same edge as a transmit strobe and a receive strobe. A byte handshake can land on the edge where the last queued bit leaves, or on an underrun slot. The sweep changes the polarity bits in the middle of traffic, always on a cycle whose strobes are active. Because `tx_valid` is offered almost all the time, handshakes collide with slot edges. A bench model that applies the old polarity for the shared edge, and ranks a send ahead of a byte intake, predicts `tx_ser`, `tx_ready` and the received bytes in every cycle.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  // An enable pin is active when its level equals the polarity bit
  // (0 = active-low, 1 = active-high).
  function automatic logic en_active(input logic pin, input logic pol);
    return pin == pol;
  endfunction
endpackage

// File: rtl/gsp_pol_regs.sv
module gsp_pol_regs (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tx_pol_in,
  input  logic rx_pol_in,
  output logic tx_pol,
  output logic rx_pol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pol <= 1'b0;
      rx_pol <= 1'b0;
    end else if (load) begin
      tx_pol <= tx_pol_in;
      rx_pol <= rx_pol_in;
    end
  end

  p_pol_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(tx_pol) && $stable(rx_pol)));
endmodule

// File: rtl/gsp_tx_serializer.sv
module gsp_tx_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en_pin,
  input  logic         pol,
  input  logic [W-1:0] data,
  input  logic         valid,
  output logic         ready,
  output logic         ser
);
  import gsp_pkg::*;
  localparam int CW = $clog2(W + 1);

  logic         go_q;
  logic         buf_full_q;
  logic [W-1:0] buf_q;
  logic [W-1:0] sh_q;
  logic [CW-1:0] left_q;
  logic         ser_q;

  // Named events for the assertions
  wire slot     = tick && go_q;
  wire have_sh  = (left_q != '0);
  wire reload   = slot && !have_sh && buf_full_q;
  wire shift    = slot && have_sh;
  wire adv      = reload || shift;
  wire underrun = slot && !have_sh && !buf_full_q;
  wire take     = valid && !buf_full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q       <= 1'b0;
      buf_full_q <= 1'b0;
      buf_q      <= '0;
      sh_q       <= '0;
      left_q     <= '0;
      ser_q      <= 1'b0;
    end else begin
      if (tick) go_q <= en_active(en_pin, pol);
      if (take) begin
        buf_q      <= data;
        buf_full_q <= 1'b1;
      end
      if (reload) begin
        ser_q      <= buf_q[W-1];
        sh_q       <= {buf_q[W-2:0], 1'b0};
        left_q     <= CW'(W - 1);
        buf_full_q <= 1'b0;
      end else if (shift) begin
        ser_q  <= sh_q[W-1];
        sh_q   <= {sh_q[W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign ready = !buf_full_q;
  assign ser   = ser_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ser));
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> !ready);
  p_underrun_r11: assert property (@(posedge clk) disable iff (rst)
    underrun |=> ($stable(left_q) && $stable(ser)));
  p_gap_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(left_q) && $stable(go_q) && $stable(ser)));
endmodule

// File: rtl/gsp_rx_deserializer.sv
module gsp_rx_deserializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en_pin,
  input  logic         pol,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         valid
);
  import gsp_pkg::*;
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [W-1:0]  data_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  wire acc  = tick && en_active(en_pin, pol);
  wire last = acc && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (acc) begin
        sh_q <= {sh_q[W-2:0], bit_in};
        if (last) begin
          cnt_q   <= '0;
          data_q  <= {sh_q[W-2:0], bit_in};
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(cnt_q) && $stable(sh_q)));
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(data));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(W));
endmodule

// File: rtl/gapped_serial_port.sv
module gapped_serial_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_load,
  input  logic         cfg_tx_pol,
  input  logic         cfg_rx_pol,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic         tx_tick,
  input  logic         tx_en,
  output logic         tx_ser,
  input  logic         rx_tick,
  input  logic         rx_en,
  input  logic         rx_ser,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  logic tx_pol;
  logic rx_pol;

  gsp_pol_regs u_pol (
    .clk(clk), .rst(rst), .load(cfg_load),
    .tx_pol_in(cfg_tx_pol), .rx_pol_in(cfg_rx_pol),
    .tx_pol(tx_pol), .rx_pol(rx_pol)
  );

  gsp_tx_serializer #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .en_pin(tx_en), .pol(tx_pol),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .ser(tx_ser)
  );

  gsp_rx_deserializer #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .en_pin(rx_en), .pol(rx_pol),
    .bit_in(rx_ser), .data(rx_data), .valid(rx_valid)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_ready && !rx_valid && !tx_ser));
endmodule

// File: tb/tb_gapped_serial_port.sv
`timescale 1ns/1ps
module tb_gapped_serial_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, cfg_load, cfg_tx_pol, cfg_rx_pol;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_ready, tx_tick, tx_en, tx_ser;
  logic rx_tick, rx_en, rx_ser, rx_valid;

  gapped_serial_port dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_tx_pol(cfg_tx_pol),
    .cfg_rx_pol(cfg_rx_pol), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_tick(tx_tick), .tx_en(tx_en), .tx_ser(tx_ser),
    .rx_tick(rx_tick), .rx_en(rx_en), .rx_ser(rx_ser), .rx_data(rx_data),
    .rx_valid(rx_valid)
  );

  int checks = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench model
  logic txq[$];
  logic m_go, m_ser, m_txpol, m_rxpol, m_rxvalid;
  logic [7:0] m_acc, m_rxdata, next_byte;
  int m_n;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] step_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // One cycle: inputs already driven at negedge; update model at posedge; compare at negedge
  task automatic cycle();
    logic rdy_old;
    @(posedge clk);
    rdy_old = (txq.size() <= 7);
    if (tx_tick) begin
      if (m_go && txq.size() > 0) m_ser = txq.pop_front();
      m_go = (tx_en == m_txpol);
    end
    if (tx_valid && rdy_old) begin
      for (int b = 7; b >= 0; b--) txq.push_back(tx_data[b]);
      next_byte = next_byte + 8'h3B;
    end
    m_rxvalid = 1'b0;
    if (rx_tick && (rx_en == m_rxpol)) begin
      m_acc = {m_acc[6:0], rx_ser};
      m_n++;
      if (m_n == 8) begin
        m_rxvalid = 1'b1;
        m_rxdata = m_acc;
        m_n = 0;
      end
    end
    if (cfg_load) begin
      m_txpol = cfg_tx_pol;
      m_rxpol = cfg_rx_pol;
    end
    @(negedge clk);
    chk("R3 R4 R5 R6 R10 R11 tx_ser", {7'd0, tx_ser}, {7'd0, m_ser});
    chk("R2 tx_ready", {7'd0, tx_ready}, {7'd0, (txq.size() <= 7)});
    chk("R7 R8 R9 rx_valid", {7'd0, rx_valid}, {7'd0, m_rxvalid});
    if (m_rxvalid) chk("R7 R9 rx_data", rx_data, m_rxdata);
  endtask

  task automatic run_phase(input int n, input logic newtx, input logic newrx, input bit do_load);
    for (int i = 0; i < n; i++) begin
      lfsr = step_lfsr(lfsr);
      cfg_load = do_load && (i == 0);
      cfg_tx_pol = newtx;
      cfg_rx_pol = newrx;
      tx_tick = (i == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
      tx_en = lfsr[3:2] != 2'b00 ? m_txpol : ~m_txpol;
      if (i % 97 > 80) tx_en = ~m_txpol;
      tx_valid = (lfsr[6:4] != 3'b000) && (i % 150 < 120);
      tx_data = next_byte;
      rx_tick = (i == 0) ? 1'b1 : (lfsr[8:7] != 2'b00);
      rx_en = lfsr[10:9] != 2'b00 ? m_rxpol : ~m_rxpol;
      rx_ser = lfsr[11] ^ lfsr[14];
      cycle();
    end
  endtask

  initial begin
    fork
      begin
        rst = 1'b1; cfg_load = 0; cfg_tx_pol = 0; cfg_rx_pol = 0;
        tx_data = 0; tx_valid = 0; tx_tick = 0; tx_en = 0;
        rx_tick = 0; rx_en = 0; rx_ser = 0;
        m_go = 0; m_ser = 0; m_txpol = 0; m_rxpol = 0; m_rxvalid = 0;
        m_acc = 0; m_rxdata = 0; m_n = 0; next_byte = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 tx_ser", {7'd0, tx_ser}, 8'd0);
        chk("R1 tx_ready", {7'd0, tx_ready}, 8'd1);
        chk("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
        // default active-low polarity (R1) exercised without any load
        run_phase(600, 1'b0, 1'b0, 1'b0);
        // polarity changes land on cycles with both strobes active (R10)
        run_phase(600, 1'b1, 1'b0, 1'b1);
        run_phase(600, 1'b0, 1'b1, 1'b1);
        run_phase(600, 1'b1, 1'b1, 1'b1);
        run_phase(600, 1'b0, 1'b0, 1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule